// File: doc/BRIEF.md
# MDIO Polling Management Master

This block is a management-bus master for Ethernet PHYs. It divides the system clock down to a management clock (MDC), shifts Clause 22 read and write frames out on a shared, released-when-idle data line, and samples the PHY's answer back in. A small four-word register port gives software a control word (enable and clock divider), a single request register, and two 32-bit status words.

While enabled and no software request is pending, a background poller walks PHY addresses 0 to 31 in turn. It reads the basic status register (register 1) of each. The answer bit of each poll is kept in the responder word, and bit 2 of the returned value in the link word. A software request is placed by writing the request register with its GO bit set. The arbiter decides only between frames, so a request arriving mid-poll waits for that frame to end and is then served ahead of the next poll.

The arbiter has six states. STOPPED: the machine is halted and the idle flag is set. It goes to CHOOSE when enable is set. CHOOSE goes to STOPPED if enable is clear, to USER_LAUNCH if GO is set, and otherwise to POLL_LAUNCH. POLL_LAUNCH and USER_LAUNCH offer a frame to the shifter and move on to POLL_BUSY or USER_BUSY once the shifter has taken it. Each BUSY state returns to CHOOSE when the frame completes.

Top module: `mdio_poll_master`

## Requirements
- R1: The register port has four words, selected by a 2-bit select: 0 control, 1 request, 2 responder word, 3 link word. After reset, control reads as bit 31 (idle) set, bit 30 (enable) clear, and bits 15:0 holding the divider reset value. The request, responder and link words read zero, and the data line is released (output enable low).
- R2: MDC has a period of D+1 system clocks. D is the control divider field, and a field of 0 counts as 1. MDC is low for the first floor((D+1)/2) clocks of each period and high for the rest.
- R3: Each frame is 64 MDC periods: 32 ones, then a 32-bit word sent most significant bit first. The word is: start 01, operation (10 read, 01 write), 5-bit PHY address, 5-bit register address, 2 turnaround bits (10 on writes), and 16 data bits.
- R4: The master changes the data line only at a falling MDC edge and samples it at a rising edge. On reads it stops driving from the first turnaround bit to the end of the frame.
- R5: The request word is laid out as bit 31 GO, bit 30 write(1)/read(0), bit 29 ACK, bits 25:21 register address, bits 20:16 PHY address, bits 15:0 data. A write with GO set launches a transaction. GO reads 1 until that frame completes and then clears.
- R6: When a read completes, bits 15:0 hold the returned value, and ACK is set only if the line was low in the second turnaround bit. With no answer, ACK is clear.
- R7: A write to the request word while GO is set is ignored.
- R8: While enabled and no request is pending, the poller reads register 1 of PHY addresses 0, 1, ..., 31 and then wraps. Responder-word bit N takes the answer flag of the latest poll of address N.
- R9: Link-word bit N takes bit 2 of the value returned by the latest poll of address N, or 0 if that poll got no answer.
- R10: A request that arrives during a poll frame is launched as the very next frame, ahead of any further poll.
- R11: Clearing enable lets the current frame finish, after which no frame starts and the idle flag reads 1. The status words hold and a pending GO stays set. Setting enable again resumes, serving the pending request first.
- R12: A completed write transaction leaves ACK clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register word select |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected word (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value when driven |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line as seen on the pad |

## Verification
The bench builds the block with a divider reset value of 5, so the reset clock period of six cycles can be measured right after reset. It then programs dividers of 0, 4 and 3. This covers the floor-to-one case, an odd period with an uneven duty split, and the short four-clock period used for all frame traffic. That period makes a full 32-address polling sweep short enough to check the responder and link words and the address order. A bench PHY answers at two addresses only, so both answered and unanswered reads are covered, as are deferral behind a poll and the stop-and-resume sequence.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
    localparam int PHY_AW     = 5;
    localparam int NPHY       = 1 << PHY_AW;
    localparam int DATA_W     = 16;
    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = 2 * PRE_BITS;
    localparam int SCAN_REG   = 1;
    localparam int LINK_BIT   = 2;

    localparam logic [1:0] SEL_CTRL  = 2'd0;
    localparam logic [1:0] SEL_USER  = 2'd1;
    localparam logic [1:0] SEL_ALIVE = 2'd2;
    localparam logic [1:0] SEL_LINK  = 2'd3;

    typedef enum logic [2:0] {
        ST_STOP,
        ST_PICK,
        ST_SCAN_LAUNCH,
        ST_SCAN_RUN,
        ST_USER_LAUNCH,
        ST_USER_RUN
    } arb_state_e;
endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
module mdio_clkgen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] last;
    logic [DIV_W:0]   span;
    logic [DIV_W-1:0] lo_len;

    always_comb begin
        last   = (div == '0) ? DIV_W'(1) : div;
        span   = {1'b0, last} + (DIV_W+1)'(1);
        lo_len = span[DIV_W:1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt >= last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

    // strobes mark the clock edge at which MDC changes level
    assign fall_stb = (cnt >= last);
    assign rise_stb = (cnt == lo_len - DIV_W'(1));
    assign mdc      = (cnt >= lo_len);
endmodule

// File: rtl/mdio_shifter.sv
`timescale 1ns/1ps
module mdio_shifter
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_stb,
    input  logic              rise_stb,
    input  logic              start,
    input  logic              is_write,
    input  logic [PHY_AW-1:0] phy,
    input  logic [PHY_AW-1:0] rega,
    input  logic [DATA_W-1:0] wdata,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int IDX_W    = $clog2(FRAME_BITS);
    localparam int TA_IDX   = PRE_BITS + 14;
    localparam int ACK_IDX  = TA_IDX + 1;
    localparam int DATA_IDX = TA_IDX + 2;

    logic [FRAME_BITS-1:0] shreg;
    logic [IDX_W-1:0]      idx;
    logic                  rd_mode;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '1;
            idx     <= '0;
            busy    <= 1'b0;
            done    <= 1'b0;
            rd_mode <= 1'b0;
            ack     <= 1'b0;
            rdata   <= '0;
        end else begin
            done <= 1'b0;
            if (fall_stb) begin
                if (busy) begin
                    if (idx == IDX_W'(FRAME_BITS - 1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        idx   <= idx + IDX_W'(1);
                        shreg <= {shreg[FRAME_BITS-2:0], 1'b1};
                    end
                end else if (start) begin
                    busy    <= 1'b1;
                    idx     <= '0;
                    rd_mode <= !is_write;
                    ack     <= 1'b0;
                    shreg   <= {{PRE_BITS{1'b1}}, 2'b01,
                                (is_write ? 2'b01 : 2'b10), phy, rega,
                                (is_write ? 2'b10 : 2'b11),
                                (is_write ? wdata : {DATA_W{1'b1}})};
                end
            end
            if (rise_stb && busy && rd_mode) begin
                if (idx == IDX_W'(ACK_IDX)) begin
                    ack <= !mdio_i;
                end
                if (idx >= IDX_W'(DATA_IDX)) begin
                    rdata <= {rdata[DATA_W-2:0], mdio_i};
                end
            end
        end
    end

    assign mdio_o  = busy ? shreg[FRAME_BITS-1] : 1'b1;
    assign mdio_oe = busy && !(rd_mode && (idx >= IDX_W'(TA_IDX)));
endmodule

// File: rtl/mdio_poll_master.sv
`timescale 1ns/1ps
module mdio_poll_master
    import mdio_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int DIV_RESET = 49
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  reg_sel,
    input  logic        reg_we,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int PAD_W = 30 - DIV_W;

    arb_state_e state, state_nxt;

    logic [DIV_W-1:0]  div_q;
    logic              en_q;
    logic              go_q, uwr_q, uack_q;
    logic [PHY_AW-1:0] ureg_q, uphy_q;
    logic [DATA_W-1:0] udata_q;
    logic [NPHY-1:0]   alive_q, link_q;
    logic [PHY_AW-1:0] scan_phy_q;

    logic              rise_stb, fall_stb;
    logic              sh_start, sh_write, sh_busy, sh_done, sh_ack;
    logic [PHY_AW-1:0] sh_phy, sh_reg;
    logic [DATA_W-1:0] sh_rdata;
    logic              idle;

    mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .div      (div_q),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall_stb (fall_stb),
        .rise_stb (rise_stb),
        .start    (sh_start),
        .is_write (sh_write),
        .phy      (sh_phy),
        .rega     (sh_reg),
        .wdata    (udata_q),
        .mdio_i   (mdio_i),
        .busy     (sh_busy),
        .done     (sh_done),
        .ack      (sh_ack),
        .rdata    (sh_rdata),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_STOP;
        else        state <= state_nxt;
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_STOP:        if (en_q) state_nxt = ST_PICK;
            ST_PICK: begin
                if (!en_q)     state_nxt = ST_STOP;
                else if (go_q) state_nxt = ST_USER_LAUNCH;
                else           state_nxt = ST_SCAN_LAUNCH;
            end
            ST_SCAN_LAUNCH: if (sh_busy) state_nxt = ST_SCAN_RUN;
            ST_SCAN_RUN:    if (sh_done) state_nxt = ST_PICK;
            ST_USER_LAUNCH: if (sh_busy) state_nxt = ST_USER_RUN;
            ST_USER_RUN:    if (sh_done) state_nxt = ST_PICK;
            default:        state_nxt = ST_STOP;
        endcase
    end

    // state outputs
    always_comb begin
        idle     = (state == ST_STOP);
        sh_start = (state == ST_SCAN_LAUNCH) || (state == ST_USER_LAUNCH);
        sh_write = (state == ST_USER_LAUNCH) && uwr_q;
        sh_phy   = (state == ST_USER_LAUNCH) ? uphy_q : scan_phy_q;
        sh_reg   = (state == ST_USER_LAUNCH) ? ureg_q : PHY_AW'(SCAN_REG);
    end

    // register file and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q      <= DIV_W'(DIV_RESET);
            en_q       <= 1'b0;
            go_q       <= 1'b0;
            uwr_q      <= 1'b0;
            uack_q     <= 1'b0;
            ureg_q     <= '0;
            uphy_q     <= '0;
            udata_q    <= '0;
            alive_q    <= '0;
            link_q     <= '0;
            scan_phy_q <= '0;
        end else begin
            if (reg_we && reg_sel == SEL_CTRL) begin
                en_q  <= reg_wdata[30];
                div_q <= reg_wdata[DIV_W-1:0];
            end
            if (reg_we && reg_sel == SEL_USER && !go_q) begin
                go_q    <= reg_wdata[31];
                uwr_q   <= reg_wdata[30];
                uack_q  <= 1'b0;
                ureg_q  <= reg_wdata[25:21];
                uphy_q  <= reg_wdata[20:16];
                udata_q <= reg_wdata[DATA_W-1:0];
            end
            if (state == ST_USER_RUN && sh_done) begin
                go_q   <= 1'b0;
                uack_q <= uwr_q ? 1'b0 : sh_ack;
                if (!uwr_q) udata_q <= sh_rdata;
            end
            if (state == ST_SCAN_RUN && sh_done) begin
                alive_q[scan_phy_q] <= sh_ack;
                link_q[scan_phy_q]  <= sh_ack & sh_rdata[LINK_BIT];
                scan_phy_q          <= scan_phy_q + PHY_AW'(1);
            end
        end
    end

    always_comb begin
        unique case (reg_sel)
            SEL_CTRL:  reg_rdata = {idle, en_q, {PAD_W{1'b0}}, div_q};
            SEL_USER:  reg_rdata = {go_q, uwr_q, uack_q, 3'b000, ureg_q, uphy_q, udata_q};
            SEL_ALIVE: reg_rdata = alive_q;
            default:   reg_rdata = link_q;
        endcase
    end
endmodule

// File: rtl/mdio_poll_master_chk.sv
`timescale 1ns/1ps
module mdio_poll_master_chk
    import mdio_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       mdc,
    input logic       mdio_o,
    input logic       mdio_oe,
    input arb_state_e state,
    input logic       sh_done,
    input logic       go,
    input logic       en,
    input logic [31:0] alive
);
    // R4: the driven level moves only together with a falling MDC edge
    a_r4_drive_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe) && !$stable(mdio_o)) |-> $fell(mdc));

    // R3: every frame opens with a preamble one
    a_r3_preamble_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> mdio_o);

    // R11: a stopped machine never drives the line
    a_r11_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP) |-> !mdio_oe);

    // R11: status words hold while stopped
    a_r11_stop_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP) |=> $stable(alive));

    // R5: GO persists until its own frame completes
    a_r5_go_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !(state == ST_USER_RUN && sh_done)) |=> go);

    // R10: a pending request wins the next frame slot
    a_r10_user_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PICK && go && en) |=> (state == ST_USER_LAUNCH));
endmodule

bind mdio_poll_master mdio_poll_master_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .state   (state),
    .sh_done (sh_done),
    .go      (go_q),
    .en      (en_q),
    .alive   (alive_q)
);

// File: tb/mdio_poll_master_test.sv
`timescale 1ns/1ps
module mdio_poll_master_test;
    import mdio_pkg::*;

    localparam int DIV_W     = 16;
    localparam int DIV_RESET = 5;
    localparam logic [63:0] RD_OE = 64'hFFFF_FFFF_FFFC_0000;

    // vector: {write, phy, reg, data, expected ack}
    localparam int NVEC = 6;
    localparam logic [27:0] VEC [NVEC] = '{
        {1'b0, 5'd3,  5'd1,  16'h0000, 1'b1},
        {1'b1, 5'd18, 5'd4,  16'hBEEF, 1'b0},
        {1'b0, 5'd7,  5'd2,  16'h0000, 1'b0},
        {1'b0, 5'd18, 5'd9,  16'h0000, 1'b1},
        {1'b1, 5'd0,  5'd31, 16'h1234, 1'b0},
        {1'b0, 5'd3,  5'd31, 16'h0000, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = 32'd0;
    wire  [31:0] reg_rdata;
    wire         mdc, mdio_out, mdio_oe, mdio_in;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #2 clk = ~clk;

    mdio_poll_master #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_out),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_in)
    );

    function automatic logic [15:0] phy_val(input logic [4:0] p, input logic [4:0] r);
        return {p, r, 3'b011, p[0], 2'b01};
    endfunction

    function automatic bit responds(input logic [4:0] p);
        return (p == 5'd3) || (p == 5'd18);
    endfunction

    function automatic logic [31:0] mk_user(input bit go, input bit w, input logic [4:0] r,
                                            input logic [4:0] p, input logic [15:0] d);
        return {go, w, 1'b0, 3'b000, r, p, d};
    endfunction

    // ---------------- bench PHY ----------------
    int          bc = 0;
    bit          active = 1'b0;
    int          frames_seen = 0;
    bit          pd_resp = 1'b0;
    logic [15:0] pd_data = 16'h0;
    logic        pd_en = 1'b0;
    logic        pd_val = 1'b1;
    logic [63:0] cap_line = 64'h0;
    logic [63:0] cap_oe = 64'h0;
    logic [63:0] flog_line [0:255];
    logic [63:0] flog_oe   [0:255];

    assign mdio_in = mdio_oe ? mdio_out : (pd_en ? pd_val : 1'b1);

    always @(posedge mdc) begin
        if (!active && mdio_oe) begin
            active = 1'b1;
            bc = 0;
        end
        if (active) begin
            cap_line[63-bc] = mdio_in;
            cap_oe[63-bc]   = mdio_oe;
            bc++;
            if (bc == 46) begin
                pd_resp = (cap_line[29:28] == 2'b10) && responds(cap_line[27:23]);
                pd_data = phy_val(cap_line[27:23], cap_line[22:18]);
            end
            if (bc == 64) begin
                active = 1'b0;
                pd_resp = 1'b0;
                flog_line[frames_seen % 256] = cap_line;
                flog_oe[frames_seen % 256]   = cap_oe;
                frames_seen++;
            end
        end
    end

    always @(negedge mdc) begin
        pd_en  = pd_resp && active && (bc >= 47) && (bc <= 63);
        pd_val = (bc == 47) ? 1'b0 : ((bc >= 48 && bc <= 63) ? pd_data[63-bc] : 1'b1);
    end

    // ---------------- helpers ----------------
    task automatic check_eq(input string req, input string what,
                            input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] d);
        @(negedge clk);
        reg_sel = s;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_go_clear(output bit ok);
        logic [31:0] v;
        ok = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            rd(SEL_USER, v);
            if (!v[31]) begin ok = 1'b1; break; end
        end
    endtask

    task automatic wait_frames(input int target);
        for (int i = 0; i < 40000; i++) begin
            if (frames_seen >= target) break;
            @(negedge clk);
        end
    endtask

    task automatic wait_mid_frame;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (active && bc >= 5 && bc <= 20) break;
        end
    endtask

    task automatic measure(output int period, output int high);
        int t0, t1;
        @(posedge mdc); t0 = cyc;
        @(negedge mdc); t1 = cyc;
        @(posedge mdc);
        period = cyc - t0;
        high   = t1 - t0;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [31:0] v, a0, first;
        bit ok, oe_seen;
        int per, hi, f0, n, bad;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(SEL_CTRL, v);  check_eq("R1", "control after reset", 64'(v), 64'({1'b1, 1'b0, 14'd0, 16'(DIV_RESET)}));
        rd(SEL_USER, v);  check_eq("R1", "request after reset", 64'(v), 64'd0);
        rd(SEL_ALIVE, v); check_eq("R1", "responder after reset", 64'(v), 64'd0);
        rd(SEL_LINK, v);  check_eq("R1", "link after reset", 64'(v), 64'd0);
        check_eq("R1", "oe after reset", 64'(mdio_oe), 64'd0);

        // R2 divider
        measure(per, hi); measure(per, hi);
        check_eq("R2", "period reset div", 64'(per), 64'd6);
        check_eq("R2", "high time reset div", 64'(hi), 64'd3);
        wr(SEL_CTRL, 32'h0000_0000);
        measure(per, hi); measure(per, hi);
        check_eq("R2", "period div 0", 64'(per), 64'd2);
        wr(SEL_CTRL, 32'h0000_0004);
        measure(per, hi); measure(per, hi);
        check_eq("R2", "period div 4", 64'(per), 64'd5);
        check_eq("R2", "high time div 4", 64'(hi), 64'd3);

        // R8 R9 polling sweep
        wr(SEL_CTRL, 32'h4000_0003);
        wait_frames(34);
        rd(SEL_ALIVE, v); check_eq("R8", "responder word", 64'(v), 64'h0004_0008);
        rd(SEL_LINK, v);  check_eq("R9", "link word", 64'(v), 64'h0000_0008);
        check_eq("R8", "first poll header", 64'(flog_line[0][31:18]), 64'({2'b01, 2'b10, 5'd0, 5'd1}));
        bad = 0;
        for (int k = 0; k < 33; k++) begin
            if (flog_line[k+1][27:23] != flog_line[k][27:23] + 5'd1) bad++;
            if (flog_line[k][22:18] != 5'd1) bad++;
        end
        check_eq("R8", "poll order violations", 64'(bad), 64'd0);
        check_eq("R4", "poll read drive pattern", flog_oe[3], RD_OE);
        check_eq("R3", "poll preamble", 64'(flog_line[3][63:32]), 64'hFFFF_FFFF);
        check_eq("R6", "poll data on line", 64'(flog_line[3][15:0]), 64'(phy_val(5'd3, 5'd1)));

        // R10 deferral behind a poll in progress
        wait_mid_frame();
        n = frames_seen;
        wr(SEL_USER, mk_user(1'b1, 1'b0, 5'd5, 5'd18, 16'h0));
        rd(SEL_USER, v); check_eq("R5", "GO pending", 64'(v[31]), 64'd1);
        wait_go_clear(ok);
        check_eq("R5", "GO cleared", 64'(ok), 64'd1);
        check_eq("R10", "frame count at completion", 64'(frames_seen), 64'(n + 2));
        check_eq("R10", "in-flight frame was a poll", 64'(flog_line[n % 256][22:18]), 64'd1);
        check_eq("R10", "next frame was the request", 64'(flog_line[(n + 1) % 256][27:18]), 64'({5'd18, 5'd5}));
        rd(SEL_USER, v);
        check_eq("R6", "deferred read ack", 64'(v[29]), 64'd1);
        check_eq("R6", "deferred read data", 64'(v[15:0]), 64'(phy_val(5'd18, 5'd5)));

        // vector table: R3 R4 R5 R6 R12
        for (int i = 0; i < NVEC; i++) begin
            logic [27:0] e;
            logic [63:0] ln;
            e = VEC[i];
            wr(SEL_USER, mk_user(1'b1, e[27], e[21:17], e[26:22], e[16:1]));
            wait_go_clear(ok);
            check_eq("R5", "GO cleared (table)", 64'(ok), 64'd1);
            rd(SEL_USER, v);
            ln = flog_line[(frames_seen - 1) % 256];
            check_eq("R3", "preamble (table)", 64'(ln[63:32]), 64'hFFFF_FFFF);
            if (e[27]) begin
                check_eq("R12", "write leaves ACK clear", 64'(v[29]), 64'd0);
                check_eq("R3", "write frame", 64'(ln[31:0]), 64'({2'b01, 2'b01, e[26:22], e[21:17], 2'b10, e[16:1]}));
                check_eq("R4", "write drive pattern", flog_oe[(frames_seen - 1) % 256], 64'hFFFF_FFFF_FFFF_FFFF);
            end else begin
                check_eq("R6", "read ACK", 64'(v[29]), 64'(e[0]));
                if (e[0]) check_eq("R6", "read data", 64'(v[15:0]), 64'(phy_val(e[26:22], e[21:17])));
                check_eq("R3", "read header", 64'(ln[31:18]), 64'({2'b01, 2'b10, e[26:22], e[21:17]}));
                check_eq("R4", "read release pattern", flog_oe[(frames_seen - 1) % 256], RD_OE);
            end
        end

        // R11 stop, R7 ignored write, resume
        wait_mid_frame();
        f0 = frames_seen;
        wr(SEL_CTRL, 32'h0000_0003);
        ok = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            rd(SEL_CTRL, v);
            if (v[31]) begin ok = 1'b1; break; end
        end
        check_eq("R11", "idle flag after disable", 64'(ok), 64'd1);
        check_eq("R11", "current frame finished, none after", 64'(frames_seen), 64'(f0 + 1));
        rd(SEL_ALIVE, a0);
        wr(SEL_USER, mk_user(1'b1, 1'b0, 5'd7, 5'd3, 16'h0));
        first = mk_user(1'b1, 1'b0, 5'd7, 5'd3, 16'h0);
        oe_seen = 1'b0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (mdio_oe) oe_seen = 1'b1;
        end
        check_eq("R11", "no drive while stopped", 64'(oe_seen), 64'd0);
        check_eq("R11", "no frames while stopped", 64'(frames_seen), 64'(f0 + 1));
        rd(SEL_ALIVE, v); check_eq("R11", "responder word held", 64'(v), 64'(a0));
        rd(SEL_USER, v);  check_eq("R11", "request still pending", 64'(v[31]), 64'd1);
        wr(SEL_USER, mk_user(1'b1, 1'b1, 5'd2, 5'd1, 16'h5555));
        rd(SEL_USER, v);  check_eq("R7", "write during GO ignored", 64'(v), 64'(first));
        wr(SEL_CTRL, 32'h4000_0003);
        wait_go_clear(ok);
        check_eq("R11", "resume completes request", 64'(ok), 64'd1);
        check_eq("R11", "first frame after resume", 64'(flog_line[(f0 + 1) % 256][27:18]), 64'({5'd3, 5'd7}));
        rd(SEL_USER, v);
        check_eq("R6", "resumed read data", 64'(v[15:0]), 64'(phy_val(5'd3, 5'd7)));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule